// File: doc/BRIEF.md
# Fractional-N Feedback Divide Controller

This block decides, once per feedback-divider cycle, how many VCO periods the next divider cycle should last. A programmed integer part and a fractional word set the long-run average ratio. An error-feedback noise shaper, built from cascaded accumulators, turns the fraction into a short integer offset that is added to the integer part. The shaper order can be chosen from one to four. Optional dither keeps the shaper from settling into short repeating patterns.

The registered divide value is then split into loads for a dual-modulus prescaler divider. The M counter gets the quotient by the prescaler modulus and the A counter gets the remainder. The modulus is 4 or 8, so the same programmed integer gives the same total ratio with either prescaler. With fractional operation off, the fraction is ignored, the shaper is held cleared, and the divide value is exactly the integer part.

In fractional use the integer part has to leave room for the negative swing of the offset (down to -7 at fourth order). With third-order shaping and the modulus-8 prescaler it is kept at 75 or more. In integer use the modulus-8 prescaler is fine down to 72.

Top module: `fracn_divctl`

## Requirements
- R1: When `frac_en` is 0, `div_out` equals `int_part` one clock after the edge that samples it, whatever `frac_part`, `order` or the dither inputs hold.
- R2: With `frac_en` = 1 and `order` = 00, the offset `div_out - int_part` is the carry out of a FRAC_W-bit accumulator. Each cycle that accumulator adds `frac_part` plus the dither bit. With a zero fraction, no dither and a cleared accumulator, the offset is 0.
- R3: `order` selects the number of cascaded accumulator stages: 00 = one, 01 = two, 10 = three, 11 = four. Each stage adds the sum of the stage before it. The carry of stage k (k ≥ 2) enters the offset through a (k-1)-th difference. For order k the offset stays within -(2^(k-1)-1) to +2^(k-1).
- R4: Starting from a cleared state with dither off, the offsets over 2^FRAC_W cycles sum to exactly `frac_part` at first order. At order k the sum is within 2^(k-1) of `frac_part`.
- R5: With `dith_en` = 1 and `dith_sel` = 0, a constant 1 is added to the first accumulator every cycle.
- R6: With `dith_en` = 1 and `dith_sel` = 1, the LSB of a 23-bit maximal-length shift register (x^23 + x^18 + 1) is added to the first accumulator. The register is seeded to 1 by reset and shifts left every clock, taking bit22 XOR bit17 into bit0. Its state is never zero.
- R7: With P = 4 when `presc_sel` = 0 and P = 8 when `presc_sel` = 1, `m_load` = `div_out` / P and `a_load` = `div_out` mod P. This holds combinationally, so `div_out` = P·`m_load` + `a_load`.
- R8: While `frac_en` is 0, all accumulators and carry delay stages are held at zero, so a fractional run always starts from a cleared state.
- R9: During reset `div_out`, `a_load` and `m_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_part | input | INT_W | Integer part of the divide ratio |
| frac_part | input | FRAC_W | Fraction in units of 2^-FRAC_W |
| order | input | 2 | Shaper order minus one |
| frac_en | input | 1 | 1 = fractional operation, 0 = integer only |
| dith_en | input | 1 | Enables dither into the first accumulator |
| dith_sel | input | 1 | 0 = constant dither, 1 = pseudo-random dither |
| presc_sel | input | 1 | 0 = 4/5 prescaler, 1 = 8/9 prescaler |
| div_out | output | INT_W+1 | Registered instantaneous divide value |
| a_load | output | 3 | A counter load (remainder) |
| m_load | output | INT_W-1 | M counter load (quotient) |

## Verification
The bench builds the block with FRAC_W = 10 and INT_W = 9. A full fractional period is then 1024 cycles, so the exact-average property of R4 can be checked over a whole window for every order, which the 25-bit default would put far out of reach. The integer width leaves room for offsets of -7 to +8 around an integer near 100. Every divider cycle is compared against a behavioural model running on integers. This covers constant and pseudo-random dither, prescaler changes in mid-run, and re-entry into fractional mode after a clear.

// File: rtl/fracn_divctl.sv
module fracn_divctl #(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_part,
  input  logic [FRAC_W-1:0] frac_part,
  input  logic [1:0]        order,
  input  logic              frac_en,
  input  logic              dith_en,
  input  logic              dith_sel,
  input  logic              presc_sel,
  output logic [INT_W:0]    div_out,
  output logic [2:0]        a_load,
  output logic [INT_W-2:0]  m_load
);
  localparam int DIV_W = INT_W + 1;
  localparam int PRS_W = 23;
  localparam int TAP_A = 22;
  localparam int TAP_B = 17;

  logic [FRAC_W-1:0] acc1, acc2, acc3, acc4;
  logic [FRAC_W:0]   s1, s2, s3, s4;
  logic              c2d1, c3d1, c3d2, c4d1, c4d2, c4d3;
  logic [PRS_W-1:0]  prs;
  logic [DIV_W-1:0]  div_q, div_nxt;
  logic signed [4:0] off;
  logic              dbit;

  assign dbit = dith_en & (dith_sel ? prs[0] : 1'b1);
  assign s1 = {1'b0, acc1} + {1'b0, frac_part} + {{FRAC_W{1'b0}}, dbit};
  assign s2 = {1'b0, acc2} + {1'b0, s1[FRAC_W-1:0]};
  assign s3 = {1'b0, acc3} + {1'b0, s2[FRAC_W-1:0]};
  assign s4 = {1'b0, acc4} + {1'b0, s3[FRAC_W-1:0]};

  always_comb begin
    off = 5'(s1[FRAC_W]);
    if (order >= 2'd1)
      off = off + 5'(s2[FRAC_W]) - 5'(c2d1);
    if (order >= 2'd2)
      off = off + 5'(s3[FRAC_W]) - 5'({c3d1, 1'b0}) + 5'(c3d2);
    if (order == 2'd3)
      off = off + 5'(s4[FRAC_W]) - 5'({c4d1, c4d1}) + 5'({c4d2, c4d2}) - 5'(c4d3);
  end

  assign div_nxt = frac_en ? DIV_W'(int_part) + {{(DIV_W-5){off[4]}}, off}
                           : DIV_W'(int_part);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc1 <= '0; acc2 <= '0; acc3 <= '0; acc4 <= '0;
      c2d1 <= 1'b0; c3d1 <= 1'b0; c3d2 <= 1'b0;
      c4d1 <= 1'b0; c4d2 <= 1'b0; c4d3 <= 1'b0;
      prs   <= PRS_W'(1);
      div_q <= '0;
    end else begin
      prs   <= {prs[PRS_W-2:0], prs[TAP_A] ^ prs[TAP_B]};
      div_q <= div_nxt;
      if (!frac_en) begin
        acc1 <= '0; acc2 <= '0; acc3 <= '0; acc4 <= '0;
        c2d1 <= 1'b0; c3d1 <= 1'b0; c3d2 <= 1'b0;
        c4d1 <= 1'b0; c4d2 <= 1'b0; c4d3 <= 1'b0;
      end else begin
        acc1 <= s1[FRAC_W-1:0];
        acc2 <= s2[FRAC_W-1:0];
        acc3 <= s3[FRAC_W-1:0];
        acc4 <= s4[FRAC_W-1:0];
        c2d1 <= s2[FRAC_W];
        c3d1 <= s3[FRAC_W]; c3d2 <= c3d1;
        c4d1 <= s4[FRAC_W]; c4d2 <= c4d1; c4d3 <= c4d2;
      end
    end
  end

  assign div_out = div_q;
  assign a_load  = presc_sel ? div_q[2:0] : {1'b0, div_q[1:0]};
  assign m_load  = presc_sel ? {1'b0, div_q[DIV_W-1:3]} : div_q[DIV_W-1:2];

  // R1: integer mode passes the integer part through unchanged
  a_r1_int_exact: assert property (@(posedge clk) disable iff (!rst_n)
    !frac_en |=> div_out == DIV_W'($past(int_part)));

  // R3: offset bounded by the selected order
  a_r3_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    frac_en |=> (int'(div_out) - int'($past(int_part)) <= (1 << $past(order))) &&
                (int'(div_out) - int'($past(int_part)) >= 1 - (1 << $past(order))));

  // R2: zero fraction on a cleared first-order accumulator gives no offset
  a_r2_zero_frac: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_en && order == 2'd0 && !dith_en && frac_part == '0 && acc1 == '0)
      |=> div_out == DIV_W'($past(int_part)));

  // R6: pseudo-random source never locks up
  a_r6_prs_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    prs != '0);
endmodule

// File: tb/sim_fracn_divctl.sv
module sim_fracn_divctl;
  localparam int CLK_PERIOD = 10;
  localparam int INT_W  = 9;
  localparam int FRAC_W = 10;
  localparam int DIV_W  = INT_W + 1;
  localparam longint WIN = longint'(1) << FRAC_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [INT_W-1:0]  int_part = '0;
  logic [FRAC_W-1:0] frac_part = '0;
  logic [1:0] order = '0;
  logic frac_en = 1'b0, dith_en = 1'b0, dith_sel = 1'b0, presc_sel = 1'b0;
  logic [DIV_W-1:0] div_out;
  logic [2:0] a_load;
  logic [INT_W-2:0] m_load;

  int checks = 0, errors = 0;
  longint sum_off = 0;

  fracn_divctl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .int_part(int_part), .frac_part(frac_part),
    .order(order), .frac_en(frac_en), .dith_en(dith_en), .dith_sel(dith_sel),
    .presc_sel(presc_sel), .div_out(div_out), .a_load(a_load), .m_load(m_load));

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  longint acc[4];
  longint d2, d3a, d3b, d4a, d4b, d4c, prs, exp_div;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (acc[i]) acc[i] = 0;
      d2 = 0; d3a = 0; d3b = 0; d4a = 0; d4b = 0; d4c = 0;
      prs = 1; exp_div = 0;
    end else begin
      longint d, s, c[4], y;
      d = dith_en ? (dith_sel ? (prs & 1) : 1) : 0;
      if (!frac_en) begin
        foreach (acc[i]) acc[i] = 0;
        d2 = 0; d3a = 0; d3b = 0; d4a = 0; d4b = 0; d4c = 0;
        exp_div = int_part;
      end else begin
        s = acc[0] + frac_part + d;
        c[0] = s / WIN; acc[0] = s % WIN;
        for (int k = 1; k < 4; k++) begin
          s = acc[k] + acc[k-1];
          c[k] = s / WIN; acc[k] = s % WIN;
        end
        y = c[0];
        if (order >= 1) y += c[1] - d2;
        if (order >= 2) y += c[2] - 2*d3a + d3b;
        if (order == 3) y += c[3] - 3*d4a + 3*d4b - d4c;
        exp_div = longint'(int_part) + y;
        d2 = c[1]; d3b = d3a; d3a = c[2]; d4c = d4b; d4b = d4a; d4a = c[3];
      end
      prs = ((prs << 1) | (((prs >> 22) ^ (prs >> 17)) & 1)) & 64'h7FFFFF;
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic cycle_check(string tag);
    longint p, o;
    p = presc_sel ? 8 : 4;
    chk(div_out == exp_div, tag, "div_out", div_out, exp_div);
    chk(a_load == div_out % p, "R7", "a_load", a_load, div_out % p);
    chk(m_load == div_out / p, "R7", "m_load", m_load, div_out / p);
    if (frac_en) begin
      o = longint'(div_out) - longint'(int_part);
      sum_off += o;
      chk(o <= (1 << order) && o >= 1 - (1 << order), "R3", "offset range",
          o, 1 << order);
    end
  endtask

  task automatic step(int n, string tag);
    repeat (n) begin
      @(negedge clk);
      cycle_check(tag);
    end
  endtask

  task automatic window(int ord, int fr);
    longint dev;
    frac_en = 1'b0; step(2, "R8");
    order = 2'(ord); frac_part = FRAC_W'(fr); dith_en = 1'b0;
    frac_en = 1'b1; sum_off = 0;
    step(int'(WIN), ord == 0 ? "R2" : "R3");
    dev = sum_off - fr;
    if (ord == 0) chk(dev == 0, "R4", "first-order window sum", sum_off, fr);
    else chk(dev <= (1 << ord) && dev >= -(1 << ord), "R4", "window sum", sum_off, fr);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int_part = 9'd100;
    repeat (3) @(negedge clk);
    chk(div_out == 0, "R9", "reset div_out", div_out, 0);
    chk(a_load == 0, "R9", "reset a_load", a_load, 0);
    chk(m_load == 0, "R9", "reset m_load", m_load, 0);
    rst_n = 1'b1;

    // R1: integer mode ignores fraction, order and dither
    for (int i = 0; i < 24; i++) begin
      frac_part = FRAC_W'($urandom); order = 2'(i); dith_en = i[2]; dith_sel = i[3];
      presc_sel = i[0]; int_part = 9'(72 + i);
      step(1, "R1");
      chk(div_out == 72 + i, "R1", "integer pass-through", div_out, 72 + i);
    end
    int_part = 9'd100; presc_sel = 1'b0;

    // R2/R3/R4/R8: one full window per order, both prescalers
    window(0, 300);
    presc_sel = 1'b1;
    window(1, 517);
    window(2, 1);
    presc_sel = 1'b0;
    window(3, 1023);
    window(0, 0);

    // R5: constant dither
    frac_en = 1'b0; step(2, "R8");
    order = 2'd1; frac_part = 10'd200; dith_en = 1'b1; dith_sel = 1'b0; frac_en = 1'b1;
    step(300, "R5");

    // R6: pseudo-random dither, prescaler flipping mid-run (R7)
    order = 2'd2; dith_sel = 1'b1; int_part = 9'd80;
    for (int i = 0; i < 400; i++) begin
      if (i % 37 == 0) presc_sel = ~presc_sel;
      step(1, "R6");
    end
    order = 2'd3;
    step(400, "R6");

    // R8: leave and re-enter fractional mode mid-run, restart from cleared state
    frac_en = 1'b0; step(1, "R8");
    chk(div_out == 80, "R8", "integer during clear", div_out, 80);
    frac_en = 1'b1; dith_en = 1'b0; order = 2'd0; frac_part = 10'd512;
    step(1, "R8");
    chk(div_out == 80, "R8", "first carry after clear", div_out, 80);
    step(1, "R8");
    chk(div_out == 81, "R8", "second carry after clear", div_out, 81);
    step(50, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule